// File: doc/BRIEF.md
# Top-Level Interrupt Aggregator

This block gathers every interrupt request of a peripheral controller onto one host line. Four GPIO bank summary lines and six level-sensitive peripheral sources are sampled into a 10-bit pending-status word. The bank summaries sit in the low bits. The peripheral sources sit above them in source order. A 16-bit enable register holds one global enable bit and one enable per peripheral source. The host line rises when the global enable is set and any enabled status bit is pending.

The bank summaries are never gated here, because each bank applies its own masking. The host treats its line as rising-edge triggered. Software services the block by reading the status word repeatedly until it reads zero. Each read therefore pulls the host line low for one cycle, so that a condition that is still pending produces a fresh rising edge. A clock-select enable input runs the controller. While that input is low, both registers hold their values, enable writes are dropped and the host line stays low.

Top module: `intc_agg_top`

## Requirements
- R1: After reset the status word, the enable register and the host line all read zero.
- R2: Status bits 0 to 3 show, one cycle after sampling, bank summary inputs 0 to 3. The enable register has no effect on these bits.
- R3: Status bits 4 to 9 show, one cycle after sampling, peripheral source inputs 0 to 5 in order (source k appears at bit 4+k).
- R4: Status bits 10 to 15 always read zero.
- R5: An enable write stores bit 0 (the global enable) and bits 4 to 9 (1 = source k at bit 4+k is enabled). The other bits read zero. The new value is visible in the cycle after the write.
- R6: The host line is high in the cycle after one in which all of the following hold: the global enable is set, no status read is made, the clock enable is high, and either a bank bit is pending or a source bit is pending with its enable bit set.
- R7: While the global enable bit is clear, the host line is low in the following cycle, whatever is pending.
- R8: A pending source bit whose enable bit is clear does not raise the host line.
- R9: A status read pulls the host line low in the next cycle. If the condition is still pending, the line rises again one cycle later.
- R10: While the clock enable is low, the status word and the enable register hold their values, enable writes are ignored, and the host line is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_clk_en | input | 1 | Clock-select enable; the controller runs only while this is high |
| bank_sum | input | 4 | GPIO bank summary requests, bank 0 at bit 0 |
| src_irq | input | 6 | Level-sensitive peripheral requests, source 0 at bit 0 |
| en_we | input | 1 | Enable-register write strobe |
| en_wdata | input | 16 | Enable-register write data |
| st_re | input | 1 | Status read strobe |
| st_rdata | output | 16 | Pending-status word |
| en_rdata | output | 16 | Enable-register contents |
| host_irq | output | 1 | Host interrupt line |

## Verification
The status read and the arrival or persistence of a pending condition can fall in the same cycle. In that case the line drop of R9 competes with the raise of R6. The bench provokes this by holding sources pending while it issues reads, and by starting a new source in the very cycle of a read. It then checks, cycle by cycle against its behavioural model, that the line goes low for exactly one cycle and rises again. A second overlap is an enable write in the same cycle as a read or while the clock enable is low, and the bench judges that case the same way.

// File: rtl/intc_agg_pkg.sv
package intc_agg_pkg;
    localparam int DEF_BANKS = 4;
    localparam int DEF_SRCS  = 6;
    localparam int DEF_WORD  = 16;
    localparam int GIE_POS   = 0;

    // Writable bits of the enable register: global enable plus source enables.
    function automatic logic [31:0] en_keep(input int banks, input int srcs);
        logic [31:0] m;
        m = '0;
        m[GIE_POS] = 1'b1;
        for (int k = 0; k < srcs; k++) m[banks + k] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/intc_status_cap.sv
module intc_status_cap #(
    parameter int NBANK = intc_agg_pkg::DEF_BANKS,
    parameter int NSRC  = intc_agg_pkg::DEF_SRCS,
    localparam int NST  = NBANK + NSRC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [NBANK-1:0] bank_sum,
    input  logic [NSRC-1:0]  src_irq,
    output logic [NST-1:0]   stat
);
    typedef struct packed {
        logic [NST-1:0] stat;
    } cap_t;

    cap_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (run) st_d.stat = {src_irq, bank_sum};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat = st_q.stat;
endmodule

// File: rtl/intc_enable_reg.sv
module intc_enable_reg #(
    parameter int NBANK = intc_agg_pkg::DEF_BANKS,
    parameter int NSRC  = intc_agg_pkg::DEF_SRCS,
    parameter int WORD  = intc_agg_pkg::DEF_WORD
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            we,
    input  logic [WORD-1:0] wdata,
    output logic [WORD-1:0] en
);
    localparam logic [31:0]     KEEP32 = intc_agg_pkg::en_keep(NBANK, NSRC);
    localparam logic [WORD-1:0] KEEP   = KEEP32[WORD-1:0];

    typedef struct packed {
        logic [WORD-1:0] en;
    } enr_t;

    enr_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (run && we) r_d.en = wdata & KEEP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign en = r_q.en;
endmodule

// File: rtl/intc_line_gen.sv
module intc_line_gen #(
    parameter int NBANK = intc_agg_pkg::DEF_BANKS,
    parameter int NSRC  = intc_agg_pkg::DEF_SRCS,
    parameter int WORD  = intc_agg_pkg::DEF_WORD,
    localparam int NST  = NBANK + NSRC
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            rd,
    input  logic [NST-1:0]  stat,
    input  logic [WORD-1:0] en,
    output logic            line
);
    typedef struct packed {
        logic line;
    } ln_t;

    ln_t l_d, l_q;
    logic [NSRC-1:0] src_live;

    // Per-source gating: source k is live when pending and enabled.
    for (genvar k = 0; k < NSRC; k++) begin : g_gate
        assign src_live[k] = stat[NBANK + k] & en[NBANK + k];
    end

    always_comb begin
        l_d.line = run && !rd && en[intc_agg_pkg::GIE_POS]
                   && ((|stat[NBANK-1:0]) || (|src_live));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) l_q <= '0;
        else        l_q <= l_d;
    end

    assign line = l_q.line;
endmodule

// File: rtl/intc_agg_top.sv
module intc_agg_top #(
    parameter int NBANK = intc_agg_pkg::DEF_BANKS,
    parameter int NSRC  = intc_agg_pkg::DEF_SRCS,
    parameter int WORD  = intc_agg_pkg::DEF_WORD,
    localparam int NST  = NBANK + NSRC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_clk_en,
    input  logic [NBANK-1:0] bank_sum,
    input  logic [NSRC-1:0]  src_irq,
    input  logic             en_we,
    input  logic [WORD-1:0]  en_wdata,
    input  logic             st_re,
    output logic [WORD-1:0]  st_rdata,
    output logic [WORD-1:0]  en_rdata,
    output logic             host_irq
);
    logic [NST-1:0]  stat;
    logic [WORD-1:0] en;

    intc_status_cap #(.NBANK(NBANK), .NSRC(NSRC)) u_cap (
        .clk(clk), .rst_n(rst_n), .run(ctl_clk_en),
        .bank_sum(bank_sum), .src_irq(src_irq), .stat(stat)
    );

    intc_enable_reg #(.NBANK(NBANK), .NSRC(NSRC), .WORD(WORD)) u_en (
        .clk(clk), .rst_n(rst_n), .run(ctl_clk_en),
        .we(en_we), .wdata(en_wdata), .en(en)
    );

    intc_line_gen #(.NBANK(NBANK), .NSRC(NSRC), .WORD(WORD)) u_line (
        .clk(clk), .rst_n(rst_n), .run(ctl_clk_en), .rd(st_re),
        .stat(stat), .en(en), .line(host_irq)
    );

    assign st_rdata = {{(WORD-NST){1'b0}}, stat};
    assign en_rdata = en;
endmodule

// File: rtl/intc_agg_chk.sv
module intc_agg_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ctl_clk_en,
    input logic [3:0]  bank_sum,
    input logic [5:0]  src_irq,
    input logic        st_re,
    input logic [15:0] st_rdata,
    input logic [15:0] en_rdata,
    input logic        host_irq
);
    assert_bank_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_clk_en |=> st_rdata[3:0] == $past(bank_sum));

    assert_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_clk_en |=> st_rdata[9:4] == $past(src_irq));

    assert_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_rdata[15:10] == 6'd0);

    assert_enbits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_rdata & 16'hFC0E) == 16'd0);

    assert_raise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_clk_en && !st_re && en_rdata[0] && (|st_rdata[3:0])) |=> host_irq);

    assert_gie_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en_rdata[0] |=> !host_irq);

    assert_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_rdata[3:0] == 4'd0 && (st_rdata[9:4] & en_rdata[9:4]) == 6'd0) |=> !host_irq);

    assert_rdlow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_re |=> !host_irq);

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_clk_en |=> (!host_irq && $stable(st_rdata) && $stable(en_rdata)));
endmodule

bind intc_agg_top intc_agg_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ctl_clk_en(ctl_clk_en),
    .bank_sum(bank_sum), .src_irq(src_irq), .st_re(st_re),
    .st_rdata(st_rdata), .en_rdata(en_rdata), .host_irq(host_irq)
);

// File: tb/sim_intc_agg_top.sv
`timescale 1ns/1ps
module sim_intc_agg_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_clk_en = 1'b1;
    logic [3:0]  bank_sum = '0;
    logic [5:0]  src_irq = '0;
    logic        en_we = 1'b0;
    logic [15:0] en_wdata = '0;
    logic        st_re = 1'b0;
    logic [15:0] st_rdata, en_rdata;
    logic        host_irq;

    int checks = 0;
    int failures = 0;
    string host_tag = "R6";
    bit model_on = 1'b0;

    // behavioural reference state
    int unsigned m_stat = 0;
    int unsigned m_en = 0;
    bit m_host = 1'b0;

    always #5 clk = ~clk;

    intc_agg_top u0 (
        .clk(clk), .rst_n(rst_n), .ctl_clk_en(ctl_clk_en),
        .bank_sum(bank_sum), .src_irq(src_irq), .en_we(en_we),
        .en_wdata(en_wdata), .st_re(st_re), .st_rdata(st_rdata),
        .en_rdata(en_rdata), .host_irq(host_irq)
    );

    task automatic check(input string req, input int unsigned act, input int unsigned exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model: advances on each rising edge from the inputs applied.
    always @(posedge clk) begin
        bit want;
        int unsigned live;
        if (!rst_n) begin
            m_stat = 0; m_en = 0; m_host = 1'b0;
        end else if (ctl_clk_en) begin
            live = (m_stat >> 4) & (m_en >> 4) & 32'h3F;
            want = (m_en % 2 == 1) && (((m_stat & 32'hF) != 0) || live != 0) && !st_re;
            m_stat = bank_sum + src_irq * 16;
            if (en_we) m_en = en_wdata & 32'h03F1;
            m_host = want;
        end else begin
            m_host = 1'b0;
        end
    end

    // Compare every clock, away from the active edge.
    always @(negedge clk) begin
        if (model_on && rst_n) begin
            check("R2", st_rdata[3:0], m_stat & 32'hF);
            check("R3", st_rdata[9:4], (m_stat >> 4) & 32'h3F);
            check("R4", st_rdata[15:10], 0);
            check("R5", en_rdata, m_en);
            check(host_tag, host_irq, m_host);
        end
    end

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_en(input logic [15:0] v);
        en_we = 1'b1; en_wdata = v; tick(); en_we = 1'b0;
    endtask

    task automatic rd_st();
        st_re = 1'b1; tick(); st_re = 1'b0;
    endtask

    initial begin
        #(10 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [15:0] lf;
        tick(2);
        check("R1", st_rdata, 0);
        check("R1", en_rdata, 0);
        check("R1", host_irq, 0);
        rst_n = 1'b1;
        model_on = 1'b1;
        tick();

        // bank pending, global enable clear
        host_tag = "R7";
        bank_sum = 4'b0101; tick(3);
        check("R2", st_rdata[3:0], 4'b0101);
        check("R7", host_irq, 0);

        // global enable on: bank summaries raise the line
        host_tag = "R6";
        wr_en(16'h0001); tick(2);
        check("R6", host_irq, 1);

        // source pending but not enabled
        host_tag = "R8";
        bank_sum = 4'b0000; src_irq = 6'b000100; tick(3);
        check("R3", st_rdata[9:4], 6'b000100);
        check("R8", host_irq, 0);

        // enable source 2 (bit 6)
        host_tag = "R6";
        wr_en(16'h0041); tick(2);
        check("R6", host_irq, 1);

        // read while still pending: one low cycle, then high again
        host_tag = "R9";
        rd_st();
        check("R9", host_irq, 0);
        tick();
        check("R9", host_irq, 1);

        // new source arriving in the cycle of a read
        src_irq = 6'b100100; st_re = 1'b1; tick(); st_re = 1'b0;
        check("R9", host_irq, 0);
        tick();
        check("R9", host_irq, 1);
        check("R3", st_rdata[9:4], 6'b100100);

        // only writable bits are kept
        host_tag = "R6";
        wr_en(16'hFFFF);
        check("R5", en_rdata, 16'h03F1);
        wr_en(16'h0000);
        check("R5", en_rdata, 16'h0000);
        wr_en(16'h0201);

        // clock enable low: hold, ignore writes, line low
        host_tag = "R10";
        ctl_clk_en = 1'b0;
        src_irq = 6'b000000; bank_sum = 4'b1111;
        en_we = 1'b1; en_wdata = 16'h0000; tick(); en_we = 1'b0;
        check("R10", host_irq, 0);
        check("R10", en_rdata, 16'h0201);
        check("R10", st_rdata, 16'h0240);
        tick(2);
        ctl_clk_en = 1'b1; tick(3);
        host_tag = "R6";
        check("R6", host_irq, 1);

        // pseudo-random stress against the model
        lf = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            host_tag = "R6";
            bank_sum   = (lf[3:0] & {4{lf[15]}});
            src_irq    = lf[9:4];
            st_re      = (lf[12:10] == 3'b000);
            en_we      = (lf[14:13] == 2'b11);
            en_wdata   = {lf[7:0], lf[15:8]};
            ctl_clk_en = (lf[11:9] != 3'b111);
            tick();
        end
        st_re = 1'b0; en_we = 1'b0; ctl_clk_en = 1'b1;
        tick(2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule